// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits between a UART receiver that delivers 9-bit words and the receive FIFO on a multidrop serial line. A word whose ninth bit is set is treated as an address. The block compares it with two configured station addresses: one private to this node, one shared by a group of nodes. A matching address opens the receive path and a mismatching one closes it. Address words are never stored. Data words pass to the FIFO only while the path is open.

The filter also produces a transmitter enable. In the free mode the transmitter is always allowed. In the gated mode it follows the receive match, so a node only talks after it has been addressed.

Top module: `mdrop_addr_filter`

## Requirements
- R1: A received word (`rx_valid_i` high) is an address when bit 8 of `rx_word_i` is 1, and a data byte when bit 8 is 0; bits 7:0 carry the byte.
- R2: An address word matches when bits 7:0 equal `ucast_addr_i`, `mcast_addr_i`, or both; after a matching address `rx_en_o` is 1 in the next cycle.
- R3: An address word, matching or not, never produces a FIFO write.
- R4: A data byte received while `rx_en_o` is 1 gives `fifo_wr_o` = 1 for exactly one cycle, in the cycle after `rx_valid_i`, with `fifo_data_o` equal to bits 7:0 of the word.
- R5: An address word that matches neither register clears `rx_en_o` in the next cycle, and data bytes received while `rx_en_o` is 0 produce no FIFO write.
- R6: A later matching address re-opens the receive path after it was closed.
- R7: With `tx_gate_i` = 0 (free mode), `tx_en_o` is 1 at all times, regardless of match state.
- R8: With `tx_gate_i` = 1 (gated mode), `tx_en_o` equals `rx_en_o`.
- R9: Data bytes never change `rx_en_o`.
- R10: After reset `rx_en_o` = 0 and `fifo_wr_o` = 0, so data is discarded until the first matching address, and in gated mode `tx_en_o` = 0.
- R11: Without `rx_valid_i` no FIFO write occurs and `rx_en_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_word_i | input | 9 | Received word; bit 8 is the address flag |
| rx_valid_i | input | 1 | One-cycle strobe marking a new received word |
| ucast_addr_i | input | 8 | Node-private address |
| mcast_addr_i | input | 8 | Group address |
| tx_gate_i | input | 1 | 0: transmitter always enabled, 1: gated by match |
| fifo_wr_o | output | 1 | Receive FIFO write strobe |
| fifo_data_o | output | 8 | Byte to write into the receive FIFO |
| rx_en_o | output | 1 | Receive path open (address match in effect) |
| tx_en_o | output | 1 | Transmitter enable |

## Verification
All 512 possible words are fed to the filter, each after a matching address has opened the path. Address words show whether the ninth bit alone decides the address/data split and whether the comparison against each register is exact. Data words show whether bytes pass intact. Each word is followed by a probe data byte, which tells an open path from a closed one at the FIFO port. The sweep is repeated with distinct unicast and multicast values, with equal values, and in both transmitter modes. This separates a match on either register from a match on one only, and free transmit from gated transmit.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic {
    TX_FREE  = 1'b0,
    TX_GATED = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/mdrop_addr_cmp.sv
module mdrop_addr_cmp #(
  parameter int DATA_W   = 8,
  parameter int NUM_ADDR = 2
) (
  input  logic [DATA_W:0]                   word_i,
  input  logic [NUM_ADDR-1:0][DATA_W-1:0]   addr_tab_i,
  output logic                              is_addr_o,
  output logic                              hit_o
);
  logic [NUM_ADDR-1:0] eq;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
    assign eq[g] = (word_i[DATA_W-1:0] == addr_tab_i[g]);
  end

  assign is_addr_o = word_i[DATA_W];
  assign hit_o     = is_addr_o & (|eq);
endmodule

// File: rtl/mdrop_match_reg.sv
module mdrop_match_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic hit_i,
  output logic en_o
);
  // only address words load; data words leave the state alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= 1'b0;
    else if (load_i) en_o <= hit_i;
  end
endmodule

// File: rtl/mdrop_wr_stage.sv
module mdrop_wr_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_addr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o
);
  logic pass;
  assign pass = valid_i & ~is_addr_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      wr_o <= pass;
      if (pass) data_o <= data_i;
    end
  end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W:0]   rx_word_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] ucast_addr_i,
  input  logic [DATA_W-1:0] mcast_addr_i,
  input  logic              tx_gate_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              rx_en_o,
  output logic              tx_en_o
);
  import mdrop_pkg::*;

  localparam int NUM_ADDR = 2;

  logic [NUM_ADDR-1:0][DATA_W-1:0] addr_tab;
  logic                            is_addr;
  logic                            hit;
  tx_mode_e                        tx_mode;

  assign addr_tab = {mcast_addr_i, ucast_addr_i};
  assign tx_mode  = tx_mode_e'(tx_gate_i);

  mdrop_addr_cmp #(.DATA_W(DATA_W), .NUM_ADDR(NUM_ADDR)) u_cmp (
    .word_i     (rx_word_i),
    .addr_tab_i (addr_tab),
    .is_addr_o  (is_addr),
    .hit_o      (hit)
  );

  mdrop_match_reg u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rx_valid_i & is_addr),
    .hit_i  (hit),
    .en_o   (rx_en_o)
  );

  mdrop_wr_stage #(.DATA_W(DATA_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .is_addr_i (is_addr),
    .en_i      (rx_en_o),
    .data_i    (rx_word_i[DATA_W-1:0]),
    .wr_o      (fifo_wr_o),
    .data_o    (fifo_data_o)
  );

  always_comb begin
    unique case (tx_mode)
      TX_GATED: tx_en_o = rx_en_o;
      default:  tx_en_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W:0]   rx_word_i,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] ucast_addr_i,
  input logic [DATA_W-1:0] mcast_addr_i,
  input logic              tx_gate_i,
  input logic              fifo_wr_o,
  input logic [DATA_W-1:0] fifo_data_o,
  input logic              rx_en_o,
  input logic              tx_en_o
);
  logic adr, dat, match;
  assign adr   = rx_valid_i & rx_word_i[DATA_W];
  assign dat   = rx_valid_i & ~rx_word_i[DATA_W];
  assign match = (rx_word_i[DATA_W-1:0] == ucast_addr_i) | (rx_word_i[DATA_W-1:0] == mcast_addr_i);

  AST_ADDR_HIT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni) adr && match |=> rx_en_o); // R2
  AST_ADDR_NOT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni) adr |=> !fifo_wr_o); // R3
  AST_DATA_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat && rx_en_o |=> fifo_wr_o && fifo_data_o == $past(rx_word_i[DATA_W-1:0])); // R4
  AST_ADDR_MISS_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni) adr && !match |=> !rx_en_o); // R5
  AST_DATA_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni) dat && !rx_en_o |=> !fifo_wr_o); // R5
  AST_TX_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni) !tx_gate_i |-> tx_en_o); // R7
  AST_TX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_gate_i |-> tx_en_o == rx_en_o); // R8
  AST_DATA_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni) dat |=> $stable(rx_en_o)); // R9
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) !rx_valid_i |=> !fifo_wr_o && $stable(rx_en_o)); // R11
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mdrop_addr_filter_test.sv
`timescale 1ns/1ps
module mdrop_addr_filter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] rx_word_i = '0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] ucast_addr_i = 8'h00;
  logic [7:0] mcast_addr_i = 8'h00;
  logic       tx_gate_i = 1'b0;
  logic       fifo_wr_o;
  logic [7:0] fifo_data_o;
  logic       rx_en_o;
  logic       tx_en_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  exp_en = 1'b0;

  always #5 clk_i = ~clk_i;

  mdrop_addr_filter uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one word for one cycle, then compare outputs against the model
  task automatic send(input logic [8:0] w);
    bit exp_wr;
    rx_word_i  = w;
    rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    if (w[8]) begin
      exp_wr = 1'b0;                                             // R1 R3
      exp_en = (w[7:0] == ucast_addr_i) || (w[7:0] == mcast_addr_i); // R2 R5 R6
    end else begin
      exp_wr = exp_en;                                           // R4 R5 R9
    end
    chk(fifo_wr_o == exp_wr, w[8] ? "R3" : "R4", fifo_wr_o, exp_wr);
    if (exp_wr) chk(fifo_data_o == w[7:0], "R4", fifo_data_o, w[7:0]);
    chk(rx_en_o == exp_en, w[8] ? "R2" : "R9", rx_en_o, exp_en);
    if (tx_gate_i) chk(tx_en_o == exp_en, "R8", tx_en_o, exp_en);
    else           chk(tx_en_o == 1'b1, "R7", tx_en_o, 1);
  endtask

  task automatic idle_check;
    @(negedge clk_i);
    chk(fifo_wr_o == 1'b0, "R11", fifo_wr_o, 0);
    chk(rx_en_o == exp_en, "R11", rx_en_o, exp_en);
  endtask

  initial begin
    logic [7:0] u_tab [3];
    logic [7:0] m_tab [3];
    u_tab[0] = 8'h3C; m_tab[0] = 8'hC3;
    u_tab[1] = 8'h00; m_tab[1] = 8'hFF;
    u_tab[2] = 8'h5A; m_tab[2] = 8'h5A;

    tx_gate_i = 1'b1;
    ucast_addr_i = u_tab[0];
    mcast_addr_i = m_tab[0];
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(rx_en_o == 1'b0, "R10", rx_en_o, 0);
    chk(fifo_wr_o == 1'b0, "R10", fifo_wr_o, 0);
    chk(tx_en_o == 1'b0, "R10", tx_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rx_en_o == 1'b0, "R10", rx_en_o, 0);
    exp_en = 1'b0;
    send(9'h012);   // R10 data before any address is dropped
    idle_check();

    for (int p = 0; p < 3; p++) begin
      ucast_addr_i = u_tab[p];
      mcast_addr_i = m_tab[p];
      for (int md = 0; md < 2; md++) begin
        tx_gate_i = md[0];
        for (int w = 0; w < 512; w++) begin
          send({1'b1, (w[0] ? mcast_addr_i : ucast_addr_i)}); // R2 R6 reopen
          send(w[8:0]);
          send({1'b0, w[7:0] ^ 8'hA5});                        // probe R5 R9
        end
        idle_check();
      end
    end

    // R5 then R6 explicit sequence
    ucast_addr_i = 8'h11; mcast_addr_i = 8'h22; tx_gate_i = 1'b1;
    send(9'h111);
    send(9'h133);
    send(9'h044);
    send(9'h122);
    send(9'h055);
    idle_check();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule